// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction per clock cycle. Its instruction set is small: word load, word store, register add, subtract, AND, OR, signed set-less-than, branch-on-equal and an absolute jump. The core contains the program counter, a 32-entry register file, an ALU, the sign extender, a main decoder, a second decoder that chooses the ALU operation, and the steering multiplexers that connect them. All control is combinational. State changes only on the rising clock edge.

Decoding takes two steps. The main decoder turns the opcode into steering controls and a 2-bit operation class. Memory-class instructions force an add, branch-class instructions force a subtract, and the register class defers to the funct field. The ALU-control decoder then reduces that class and the funct field to a 4-bit ALU operation. The destination register comes from the rd field for register operations and from the rt field for loads.

Instruction memory and data memory are small word arrays inside the core. Their reads are combinational and their writes take effect at the clock edge. A testbench or host fills them through a preload port while the core is held in reset. Register-file writes and data-memory writes appear on observation outputs in the same cycle as the instruction that makes them.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears every register to zero. While `rst` is high, no register or data-memory write reaches the observation outputs.
- R2: For register-class instructions (opcode 0), loads (opcode 35) and stores (opcode 43), the next program counter is the current one plus 4.
- R3: A register-class instruction writes `rs op rt` into rd (bits 15:11). The funct field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, and 0x2A set-less-than. Set-less-than returns 1 when rs < rt as signed numbers and 0 otherwise.
- R4: A load (opcode 35) writes data-memory word `(rs + sign-extended imm[15:0])[AW+1:2]` into rt (bits 20:16).
- R5: A store (opcode 43) writes rt into the data-memory word at `rs + sign-extended imm`. The new value is visible to a load in a later cycle. A store writes no register.
- R6: A branch (opcode 4) sets the next program counter to `PC+4 + (sign-extended imm << 2)` when rs equals rt, and to PC+4 otherwise. A branch writes no register and no memory.
- R7: A jump (opcode 2) sets the next program counter to `{(PC+4)[31:28], instr[25:0], 2'b00}`.
- R8: Register 0 always reads as zero. Writes aimed at register 0, whether from an ALU result or a load, leave it unchanged.
- R9: When `load_en` is high, `load_data` is written at the clock edge to word `load_addr`. The target is instruction memory when `load_sel` is 0 and data memory when `load_sel` is 1. A preload write takes priority over a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write strobe |
| load_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr | input | max(IMEM_AW,DMEM_AW) | Preload word index |
| load_data | input | 32 | Preload word value |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write in this cycle |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value being written to the register |
| dm_we_o | output | 1 | Data-memory store in this cycle |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (rt value) |

## Verification
The assertions assume that every fetched word is one of the nine supported instructions. They also assume that the instruction memory has been filled wherever the program counter can land, so that no unknown opcode drives the decoder. The bench therefore writes a complete program for each scenario, including a register-0 no-op at every address a branch or jump might reach. It asserts reset again before the fall-through word can matter. Memory addresses are word aligned and stay inside the data array, so address wrap-around never comes into play.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_JMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ  = 6'd4;
    localparam logic [5:0] OPC_LOAD = 6'd35;
    localparam logic [5:0] OPC_STOR = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10
    } op_class_e;

    typedef struct packed {
        logic      dst_rd;
        logic      src_imm;
        logic      wb_mem;
        logic      reg_we;
        logic      mem_rd;
        logic      mem_we;
        logic      branch;
        logic      jump;
        op_class_e cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
                 mem_rd: 1'b0, mem_we: 1'b0, branch: 1'b0, jump: 1'b0,
                 cls: CLS_MEM};
        case (opcode)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.cls    = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OPC_STOR: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_CMP;
            end
            OPC_JMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  op_class_e  cls,
    input  logic [5:0] funct,
    output alu_op_e    alu_op
);
    always_comb begin
        alu_op = ALU_ADD;
        case (cls)
            CLS_MEM: alu_op = ALU_ADD;
            CLS_CMP: alu_op = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  alu_op = ALU_ADD;
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: alu_op = ALU_ADD;
                endcase
            end
            default: alu_op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [W-1:0] diff;

    assign diff = a - b;

    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] ra_a,
    input  logic [$clog2(DEPTH)-1:0] ra_b,
    output logic [W-1:0]             rd_a,
    output logic [W-1:0]             rd_b,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wa,
    input  logic [W-1:0]             wd
);
    logic [W-1:0] regs_d [DEPTH];
    logic [W-1:0] regs_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            regs_q[i] <= regs_d[i];
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              load_en,
    input  logic                                              load_sel,
    input  logic [((IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW)-1:0] load_addr,
    input  logic [31:0]                                       load_data,
    output logic [31:0]                                       pc_o,
    output logic                                              rf_we_o,
    output logic [4:0]                                        rf_waddr_o,
    output logic [31:0]                                       rf_wdata_o,
    output logic                                              dm_we_o,
    output logic [31:0]                                       dm_addr_o,
    output logic [31:0]                                       dm_wdata_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    alu_op_e         alu_op;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y;
    logic            alu_zero;
    logic [RAW-1:0]  dst_reg;
    logic [XLEN-1:0] dm_rdata, wb_data;
    logic [XLEN-1:0] pc_plus4, br_target, jmp_target;
    logic            im_we, dm_we, core_st_we, core_rf_we;
    logic [DMEM_AW-1:0] dm_waddr;
    logic [XLEN-1:0] dm_wdata;

    // Fetch
    assign im_we = load_en & ~load_sel;

    sc_ram #(.W(XLEN), .AW(IMEM_AW)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (load_addr[IMEM_AW-1:0]),
        .wdata (load_data),
        .raddr (st_q.pc[IMEM_AW+1:2]),
        .rdata (instr)
    );

    // Decode
    sc_main_dec u_main_dec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .cls    (ctrl.cls),
        .funct  (instr[5:0]),
        .alu_op (alu_op)
    );

    assign dst_reg    = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign core_rf_we = ctrl.reg_we & ~rst;
    assign core_st_we = ctrl.mem_we & ~rst;

    sc_regfile #(.W(XLEN), .DEPTH(NREG)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (instr[25:21]),
        .ra_b (instr[20:16]),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (core_rf_we),
        .wa   (dst_reg),
        .wd   (wb_data)
    );

    // Execute
    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Memory: a preload write wins over a store
    assign dm_we    = (load_en & load_sel) | core_st_we;
    assign dm_waddr = (load_en & load_sel) ? load_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
    assign dm_wdata = (load_en & load_sel) ? load_data : rt_val;

    sc_ram #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[DMEM_AW+1:2]),
        .rdata (dm_rdata)
    );

    // Write back
    assign wb_data = ctrl.wb_mem ? (ctrl.mem_rd ? dm_rdata : '0) : alu_y;

    // Next PC
    assign pc_plus4   = st_q.pc + 32'd4;
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        st_d = st_q;
        if (ctrl.jump) begin
            st_d.pc = jmp_target;
        end else if (ctrl.branch && alu_zero) begin
            st_d.pc = br_target;
        end else begin
            st_d.pc = pc_plus4;
        end
        if (rst) begin
            st_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign rf_we_o    = core_rf_we;
    assign rf_waddr_o = dst_reg;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = core_st_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we_o,
    input logic [4:0]  rf_waddr_o,
    input logic        dm_we_o
);
    logic [5:0]  opc;
    logic [31:0] seq_pc, tgt_br, tgt_j;

    assign opc    = instr[31:26];
    assign seq_pc = pc_o + 32'd4;
    assign tgt_br = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign tgt_j  = {seq_pc[31:28], instr[25:0], 2'b00};

    AST_RESET_PC: assert property (@(posedge clk) disable iff (1'b0)
        rst |=> (pc_o == 32'd0)); // R1

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (1'b0)
        rst |-> (!rf_we_o && !dm_we_o)); // R1

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd0 || opc == 6'd35 || opc == 6'd43) |=> (pc_o == $past(seq_pc))); // R2

    AST_REG_DEST: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd0) |-> (rf_we_o && rf_waddr_o == instr[15:11])); // R3

    AST_LOAD_DEST: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd35) |-> (rf_we_o && rf_waddr_o == instr[20:16] && !dm_we_o)); // R4

    AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> (opc == 6'd43 && !rf_we_o)); // R5

    AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4 && rs_val == rt_val) |=> (pc_o == $past(tgt_br))); // R6

    AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4 && rs_val != rt_val) |=> (pc_o == $past(seq_pc))); // R6

    AST_BR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4) |-> (!rf_we_o && !dm_we_o)); // R6

    AST_JUMP_PC: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd2) |=> (pc_o == $past(tgt_j))); // R7
endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .instr      (instr),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .dm_we_o    (dm_we_o)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_sel = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core u_sc_core (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_sel   (load_sel),
        .load_addr  (load_addr),
        .load_data  (load_data),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'd2, tgt};
    endfunction

    localparam logic [31:0] NOP = 32'h0000_0020; // add r0,r0,r0

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic sel, input int idx, input logic [31:0] val);
        @(negedge clk);
        load_en   = 1'b1;
        load_sel  = sel;
        load_addr = idx[5:0];
        load_data = val;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic start_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_first;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic next_instr;
        @(negedge clk);
        #1;
    endtask

    task automatic expect_rf(input string tag, input logic [31:0] pc,
                             input logic [4:0] rd, input logic [31:0] val);
        chk({tag, " pc"}, pc_o, pc);
        chk({tag, " rf_we"}, {31'd0, rf_we_o}, 32'd1);
        chk({tag, " rd"}, {27'd0, rf_waddr_o}, {27'd0, rd});
        chk({tag, " data"}, rf_wdata_o, val);
        chk({tag, " no store"}, {31'd0, dm_we_o}, 32'd0);
    endtask

    task automatic expect_st(input string tag, input logic [31:0] pc,
                             input logic [31:0] addr, input logic [31:0] val);
        chk({tag, " pc"}, pc_o, pc);
        chk({tag, " dm_we"}, {31'd0, dm_we_o}, 32'd1);
        chk({tag, " addr"}, dm_addr_o, addr);
        chk({tag, " data"}, dm_wdata_o, val);
        chk({tag, " no rf write"}, {31'd0, rf_we_o}, 32'd0);
    endtask

    // R1: program counter and quiet outputs while in reset
    task automatic t_reset_state;
        start_reset();
        #1;
        chk("R1 pc in reset", pc_o, 32'd0);
        chk("R1 no rf write in reset", {31'd0, rf_we_o}, 32'd0);
        chk("R1 no store in reset", {31'd0, dm_we_o}, 32'd0);
    endtask

    // R2 R3 R4 R5 R9: loads, ALU ops, stores
    task automatic t_alu_mem;
        start_reset();
        put(1, 0, 32'd7);
        put(1, 1, 32'hFFFF_FFFD);
        put(1, 2, 32'd8);
        put(0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
        put(0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd4));
        put(0, 2, enc_r(5'd1, 5'd2, 5'd3, 6'h20));
        put(0, 3, enc_r(5'd1, 5'd2, 5'd4, 6'h22));
        put(0, 4, enc_r(5'd1, 5'd2, 5'd5, 6'h24));
        put(0, 5, enc_r(5'd1, 5'd2, 5'd6, 6'h25));
        put(0, 6, enc_r(5'd2, 5'd1, 5'd7, 6'h2A));
        put(0, 7, enc_r(5'd1, 5'd2, 5'd8, 6'h2A));
        put(0, 8, enc_i(6'd43, 5'd0, 5'd3, 16'd12));
        put(0, 9, enc_i(6'd35, 5'd0, 5'd9, 16'd12));
        put(0, 10, enc_i(6'd35, 5'd0, 5'd11, 16'd8));
        put(0, 11, enc_i(6'd43, 5'd11, 5'd1, 16'hFFFC));
        put(0, 12, enc_i(6'd35, 5'd0, 5'd12, 16'd4));
        put(0, 13, NOP);
        run_first();
        expect_rf("R4 R9 lw preloaded", 32'd0, 5'd1, 32'd7);
        next_instr();
        expect_rf("R4 lw offset 4 / R2", 32'd4, 5'd2, 32'hFFFF_FFFD);
        next_instr();
        expect_rf("R3 add", 32'd8, 5'd3, 32'd4);
        next_instr();
        expect_rf("R3 sub", 32'd12, 5'd4, 32'd10);
        next_instr();
        expect_rf("R3 and", 32'd16, 5'd5, 32'd5);
        next_instr();
        expect_rf("R3 or", 32'd20, 5'd6, 32'hFFFF_FFFF);
        next_instr();
        expect_rf("R3 slt signed true", 32'd24, 5'd7, 32'd1);
        next_instr();
        expect_rf("R3 slt signed false", 32'd28, 5'd8, 32'd0);
        next_instr();
        expect_st("R5 sw", 32'd32, 32'd12, 32'd4);
        next_instr();
        expect_rf("R5 lw after sw", 32'd36, 5'd9, 32'd4);
        next_instr();
        expect_rf("R4 lw base value", 32'd40, 5'd11, 32'd8);
        next_instr();
        expect_st("R5 sw negative offset", 32'd44, 32'd4, 32'd7);
        next_instr();
        expect_rf("R5 overwrite visible", 32'd48, 5'd12, 32'd7);
    endtask

    // R8: register 0 stays zero
    task automatic t_zero_reg;
        start_reset();
        put(1, 0, 32'd9);
        put(0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
        put(0, 1, enc_r(5'd1, 5'd1, 5'd0, 6'h20));
        put(0, 2, enc_i(6'd43, 5'd0, 5'd0, 16'd16));
        put(0, 3, enc_i(6'd35, 5'd0, 5'd0, 16'd0));
        put(0, 4, enc_r(5'd0, 5'd1, 5'd2, 6'h20));
        put(0, 5, NOP);
        run_first();
        expect_rf("R8 setup lw", 32'd0, 5'd1, 32'd9);
        next_instr();
        next_instr();
        expect_st("R8 r0 after ALU write", 32'd8, 32'd16, 32'd0);
        next_instr();
        next_instr();
        expect_rf("R8 r0 after load write", 32'd16, 5'd2, 32'd9);
    endtask

    // R6 R7: branches and jump
    task automatic t_control;
        start_reset();
        put(1, 0, 32'd5);
        put(1, 1, 32'd6);
        put(0, 0, enc_i(6'd35, 5'd0, 5'd1, 16'd0));
        put(0, 1, enc_i(6'd35, 5'd0, 5'd2, 16'd0));
        put(0, 2, enc_i(6'd35, 5'd0, 5'd3, 16'd4));
        put(0, 3, enc_i(6'd4, 5'd1, 5'd3, 16'd5));
        put(0, 4, enc_i(6'd4, 5'd1, 5'd2, 16'd3));
        put(0, 5, enc_j(26'd10));
        put(0, 6, NOP);
        put(0, 7, NOP);
        put(0, 8, enc_i(6'd4, 5'd0, 5'd0, 16'hFFFC));
        put(0, 9, NOP);
        put(0, 10, NOP);
        put(0, 11, NOP);
        run_first();
        next_instr();
        next_instr();
        next_instr();
        chk("R6 beq unequal fetched", pc_o, 32'd12);
        chk("R6 beq no rf write", {31'd0, rf_we_o}, 32'd0);
        chk("R6 beq no store", {31'd0, dm_we_o}, 32'd0);
        next_instr();
        chk("R6 not taken goes to pc+4", pc_o, 32'd16);
        next_instr();
        chk("R6 taken forward", pc_o, 32'd32);
        next_instr();
        chk("R6 taken backward", pc_o, 32'd20);
        next_instr();
        chk("R7 jump target", pc_o, 32'd40);
    endtask

    // R1: reset clears registers written earlier
    task automatic t_reset_clears;
        start_reset();
        put(0, 0, enc_i(6'd43, 5'd0, 5'd3, 16'd20));
        put(0, 1, enc_i(6'd43, 5'd0, 5'd12, 16'd24));
        put(0, 2, NOP);
        run_first();
        expect_st("R1 r3 cleared", 32'd0, 32'd20, 32'd0);
        next_instr();
        expect_st("R1 r12 cleared", 32'd4, 32'd24, 32'd0);
    endtask

    logic done = 1'b0;

    initial begin
        t_reset_state();
        t_alu_mem();
        t_zero_reg();
        t_control();
        t_alu_mem();
        t_reset_clears();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule